// File: doc/BRIEF.md
# I2C Target with Page-Wrapped Write Pointer

This block is a byte-oriented I2C target for a 256-byte storage space. It runs from a fast system clock, cleans up the SCL and SDA lines with synchronizers and a majority-free agreement filter, and detects bus conditions and clock edges internally. A host reaches the storage through a plain memory port: the block presents an address, strobes write data for one cycle, and takes read data back combinationally from the same address.

A write transaction first sets an internal byte pointer, then stores each further data byte at the pointer. During writes the pointer stays inside its 8-byte page, so a long burst folds back onto the start of that page. A read transaction begins at wherever the pointer was left and walks forward through the whole space. When a write transaction that stored data ends with a STOP, the block raises a one-cycle commit request. While the storage reports busy, the block refuses to acknowledge its own address, so a master can poll for completion.

Top module: `i2c_paged_target`

## Requirements
- R1: The target address is the 7-bit value 1010 followed by the three strap bits (strap[2] first). The address byte carries these seven bits MSB first, then a direction bit (0 write, 1 read). On a match the block pulls SDA low during the 9th clock (ACK).
- R2: When the address does not match, the block drives SDA for no bit, issues no write strobe and raises no commit until the next START.
- R3: The block changes its SDA drive only while SCL is low.
- R4: In a write transaction the first byte after the address sets the pointer. Each later byte is acknowledged and produces exactly one single-cycle write strobe carrying the pointer as address and the byte as data.
- R5: After each stored byte the pointer advances within its 8-byte page. From the last byte of a page (low three bits 111) it returns to the page's first byte.
- R6: A read transaction returns bytes MSB first, starting at the current pointer without a pointer byte. After each master ACK the pointer advances over the full 8-bit space, wrapping from FFh to 00h.
- R7: After the master NACKs a read byte, the block releases SDA and leaves it released until the next START or STOP.
- R8: A STOP that ends a transaction in which at least one data byte was stored produces a commit request exactly one cycle long. A STOP after a transaction that stored nothing produces none.
- R9: While the busy input is high, the block does not acknowledge its own address.
- R10: A repeated START is treated exactly like a START; a pointer set by a write survives it and a following read starts there.
- R11: A high pulse on SCL shorter than three system clock cycles is not treated as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Level sampled on the SCL line |
| sda_i | input | 1 | Level sampled on the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 3 | Pin-strapped low address bits |
| mem_busy | input | 1 | Storage busy with a commit |
| mem_addr | output | 8 | Storage address (current pointer) |
| mem_wdata | output | 8 | Storage write data |
| mem_we | output | 1 | Single-cycle write strobe |
| mem_rdata | input | 8 | Storage read data at mem_addr |
| commit_req | output | 1 | Single-cycle commit request after STOP |

## Verification
On every cycle the assertions check that SDA drive is steady while the filtered clock is high, that write and commit strobes last one cycle and the commit only appears in the idle state, that the pointer moves inside its page after each strobe, that the ignore state never drives the bus or writes, and that an address ACK is never issued while busy. Only the bench scenarios can show the end-to-end data path: that the right bytes land at page-folded addresses, that reads return stored data across the FFh boundary and after a repeated START, that mismatched addresses and busy polling are refused, and that short SCL glitches leave transferred data intact.

// File: rtl/i2c_paged_pkg.sv
package i2c_paged_pkg;

   localparam logic [3:0] DEV_PREFIX = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ADDR   = 3'd1,
      ST_PTR    = 3'd2,
      ST_WDATA  = 3'd3,
      ST_RDATA  = 3'd4,
      ST_IGNORE = 3'd5
   } tgt_state_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
   parameter int LINES       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] raw_i,
   output logic [LINES-1:0] clean_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 2) begin : g_bad_filt
      $error("FILT_LEN must be at least 2");
   end

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [SYNC_STAGES-1:0] sync_q;
      logic [FILT_LEN-1:0]    hist_q;
      logic                   clean_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q  <= '1;
            hist_q  <= '1;
            clean_q <= 1'b1;
         end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i[g]};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q) begin
               clean_q <= 1'b1;
            end else if (~|hist_q) begin
               clean_q <= 1'b0;
            end
         end
      end

      assign clean_o[g] = clean_q;
   end

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   assign scl_rise = scl_f & ~scl_d;
   assign scl_fall = ~scl_f & scl_d;
   assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;

endmodule

// File: rtl/i2c_target_core.sv
module i2c_target_core
   import i2c_paged_pkg::*;
#(
   parameter int AW         = 8,
   parameter int PAGE_BYTES = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_ev,
   input  logic          stop_ev,
   input  logic          sda_f,
   input  logic [2:0]    strap_i,
   input  logic          busy_i,
   input  logic [7:0]    rdata_i,
   output logic          oe_o,
   output logic [AW-1:0] addr_o,
   output logic [7:0]    wdata_o,
   output logic          we_o,
   output logic          commit_o,
   output tgt_state_t    state_o
);

   localparam int PW = $clog2(PAGE_BYTES);

   tgt_state_t    state_q;
   logic [3:0]    bit_q;
   logic [7:0]    rx_q, tx_q, wd_q;
   logic [AW-1:0] ptr_q, wr_next;
   logic          rd_q, dirty_q, oe_q, we_q, commit_q;
   logic          addr_hit;

   if (PAGE_BYTES < (1 << AW)) begin : g_paged
      assign wr_next = {ptr_q[AW-1:PW], ptr_q[PW-1:0] + PW'(1)};
   end else begin : g_flat
      assign wr_next = ptr_q + 1'b1;
   end

   assign addr_hit = (rx_q[7:1] == {DEV_PREFIX, strap_i}) && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bit_q    <= 4'd0;
         rx_q     <= 8'd0;
         tx_q     <= 8'd0;
         wd_q     <= 8'd0;
         ptr_q    <= '0;
         rd_q     <= 1'b0;
         dirty_q  <= 1'b0;
         oe_q     <= 1'b0;
         we_q     <= 1'b0;
         commit_q <= 1'b0;
      end else begin
         we_q     <= 1'b0;
         commit_q <= 1'b0;
         if (we_q) begin
            ptr_q <= wr_next;
         end
         if (start_ev) begin
            state_q <= ST_ADDR;
            bit_q   <= 4'd0;
            oe_q    <= 1'b0;
         end else if (stop_ev) begin
            state_q <= ST_IDLE;
            bit_q   <= 4'd0;
            oe_q    <= 1'b0;
            if (dirty_q) begin
               commit_q <= 1'b1;
               dirty_q  <= 1'b0;
            end
         end else begin
            case (state_q)
               ST_ADDR, ST_PTR, ST_WDATA: begin
                  if (scl_rise && bit_q < 4'd8) begin
                     rx_q  <= {rx_q[6:0], sda_f};
                     bit_q <= bit_q + 4'd1;
                  end else if (scl_rise && bit_q == 4'd8) begin
                     bit_q <= 4'd9;
                  end else if (scl_fall && bit_q == 4'd8) begin
                     if (state_q == ST_ADDR) begin
                        if (addr_hit) begin
                           oe_q <= 1'b1;
                           rd_q <= rx_q[0];
                        end else begin
                           state_q <= ST_IGNORE;
                        end
                     end else if (state_q == ST_PTR) begin
                        oe_q  <= 1'b1;
                        ptr_q <= rx_q[AW-1:0];
                     end else begin
                        oe_q    <= 1'b1;
                        we_q    <= 1'b1;
                        wd_q    <= rx_q;
                        dirty_q <= 1'b1;
                     end
                  end else if (scl_fall && bit_q == 4'd9) begin
                     bit_q <= 4'd0;
                     if (state_q == ST_ADDR && rd_q) begin
                        state_q <= ST_RDATA;
                        tx_q    <= rdata_i;
                        oe_q    <= ~rdata_i[7];
                     end else begin
                        oe_q <= 1'b0;
                        if (state_q == ST_ADDR) begin
                           state_q <= ST_PTR;
                        end else if (state_q == ST_PTR) begin
                           state_q <= ST_WDATA;
                        end
                     end
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     if (bit_q == 4'd8) begin
                        if (sda_f) begin
                           state_q <= ST_IGNORE;
                        end else begin
                           ptr_q <= ptr_q + 1'b1;
                           bit_q <= 4'd9;
                        end
                     end else if (bit_q < 4'd8) begin
                        bit_q <= bit_q + 4'd1;
                     end
                  end else if (scl_fall) begin
                     if (bit_q >= 4'd1 && bit_q <= 4'd7) begin
                        tx_q <= {tx_q[6:0], 1'b0};
                        oe_q <= ~tx_q[6];
                     end else if (bit_q == 4'd8) begin
                        oe_q <= 1'b0;
                     end else if (bit_q == 4'd9) begin
                        bit_q <= 4'd0;
                        tx_q  <= rdata_i;
                        oe_q  <= ~rdata_i[7];
                     end
                  end
               end
               default: begin
                  oe_q <= 1'b0;
               end
            endcase
         end
      end
   end

   assign oe_o     = oe_q;
   assign addr_o   = ptr_q;
   assign wdata_o  = wd_q;
   assign we_o     = we_q;
   assign commit_o = commit_q;
   assign state_o  = state_q;

endmodule

// File: rtl/i2c_paged_target.sv
module i2c_paged_target
   import i2c_paged_pkg::*;
#(
   parameter int AW          = 8,
   parameter int PAGE_BYTES  = 8,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_oe,
   input  logic [2:0]    strap_i,
   input  logic          mem_busy,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata,
   output logic          mem_we,
   input  logic [7:0]    mem_rdata,
   output logic          commit_req
);

   if (AW < 1 || AW > 8) begin : g_bad_aw
      $error("AW must lie in 1..8, the pointer is loaded from one byte");
   end
   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES > (1 << AW)) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two between 2 and 2**AW");
   end

   logic [1:0] clean;
   logic       scl_f, sda_f;
   logic       scl_rise, scl_fall, start_ev, stop_ev;
   tgt_state_t core_state;

   i2c_line_filter #(
      .LINES      (2),
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
   ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  ({sda_i, scl_i}),
      .clean_o(clean)
   );

   assign scl_f = clean[0];
   assign sda_f = clean[1];

   i2c_bus_events u_ev (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_f   (scl_f),
      .sda_f   (sda_f),
      .scl_rise(scl_rise),
      .scl_fall(scl_fall),
      .start_ev(start_ev),
      .stop_ev (stop_ev)
   );

   i2c_target_core #(
      .AW        (AW),
      .PAGE_BYTES(PAGE_BYTES)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_rise(scl_rise),
      .scl_fall(scl_fall),
      .start_ev(start_ev),
      .stop_ev (stop_ev),
      .sda_f   (sda_f),
      .strap_i (strap_i),
      .busy_i  (mem_busy),
      .rdata_i (mem_rdata),
      .oe_o    (sda_oe),
      .addr_o  (mem_addr),
      .wdata_o (mem_wdata),
      .we_o    (mem_we),
      .commit_o(commit_req),
      .state_o (core_state)
   );

endmodule

// File: rtl/i2c_paged_target_chk.sv
module i2c_paged_target_chk
   import i2c_paged_pkg::*;
#(
   parameter int AW         = 8,
   parameter int PAGE_BYTES = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_f,
   input logic          sda_oe,
   input logic          mem_busy,
   input logic [AW-1:0] mem_addr,
   input logic          mem_we,
   input logic          commit_req,
   input tgt_state_t    state
);

   localparam int PW = $clog2(PAGE_BYTES);

   // R3: drive is steady while the filtered clock stays high
   a_r3_sda_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_f && $past(scl_f)) |-> $stable(sda_oe));

   // R4: write strobe lasts one cycle
   a_r4_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R5: pointer stays in its page after a stored byte
   if (PAGE_BYTES < (1 << AW)) begin : g_page_chk
      a_r5_page_fold: assert property (@(posedge clk) disable iff (!rst_n)
         mem_we |=> (mem_addr[AW-1:PW] == $past(mem_addr[AW-1:PW]))
                 && (mem_addr[PW-1:0] == $past(mem_addr[PW-1:0]) + PW'(1)));
   end

   // R8: commit request is a single cycle and follows a STOP
   a_r8_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |=> !commit_req);
   a_r8_commit_idle: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |-> (state == ST_IDLE));

   // R2 and R7: ignore state is silent on the bus and the memory port
   a_r2_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE) |-> (!sda_oe && !mem_we));

   // R9: an address ACK is never issued while busy
   a_r9_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_oe) && state == ST_ADDR) |-> !$past(mem_busy));

endmodule

bind i2c_paged_target i2c_paged_target_chk #(
   .AW        (AW),
   .PAGE_BYTES(PAGE_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_f     (scl_f),
   .sda_oe    (sda_oe),
   .mem_busy  (mem_busy),
   .mem_addr  (mem_addr),
   .mem_we    (mem_we),
   .commit_req(commit_req),
   .state     (core_state)
);

// File: tb/i2c_paged_target_tb_top.sv
module i2c_paged_target_tb_top;

   localparam int Q = 20;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
   localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       busy = 1'b0;
   logic       sda_line;
   logic       sda_oe, mem_we, commit_req;
   logic [7:0] mem_addr, mem_wdata, mem_rdata;
   logic [7:0] mem [0:255];
   int         n_checks = 0;
   int         n_errors = 0;
   int         we_cnt = 0;
   int         commit_cnt = 0;
   int         r3_viol = 0;
   logic       prev_scl = 1'b1;
   logic       prev_oe = 1'b0;

   always #10 clk = ~clk;

   assign sda_line  = sda_m & ~sda_oe;
   assign mem_rdata = mem[mem_addr];

   i2c_paged_target dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .strap_i   (STRAP),
      .mem_busy  (busy),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata),
      .commit_req(commit_req)
   );

   always @(posedge clk) begin
      if (mem_we) begin
         mem[mem_addr] <= mem_wdata;
         we_cnt <= we_cnt + 1;
      end
      if (commit_req) commit_cnt <= commit_cnt + 1;
   end

   always @(negedge clk) begin
      if (rst_n && scl_m && prev_scl && (sda_oe != prev_oe)) r3_viol <= r3_viol + 1;
      prev_scl <= scl_m;
      prev_oe  <= sda_oe;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_q(input int n);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_q(1);
      scl_m = 1'b1; wait_q(1);
      sda_m = 1'b0; wait_q(1);
      scl_m = 1'b0; wait_q(1);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_q(1);
      scl_m = 1'b1; wait_q(1);
      sda_m = 1'b1; wait_q(2);
   endtask

   task automatic send_bit(input logic b, input bit glitch);
      sda_m = b; wait_q(1);
      if (glitch) begin
         scl_m = 1'b1;
         @(negedge clk); @(negedge clk);
         scl_m = 1'b0;
         wait_q(1);
      end
      scl_m = 1'b1; wait_q(2);
      scl_m = 1'b0; wait_q(1);
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; wait_q(1);
      scl_m = 1'b1; wait_q(1);
      b = sda_line; wait_q(1);
      scl_m = 1'b0; wait_q(1);
   endtask

   task automatic write_byte(input logic [7:0] d, input bit glitch, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(d[i], glitch);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic read_byte(input logic master_ack, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      send_bit(~master_ack, 1'b0);
   endtask

   task automatic t_reset();
      check("R3 reset sda_oe", {31'd0, sda_oe}, 32'd0);
      check("R4 reset mem_we", {31'd0, mem_we}, 32'd0);
      check("R8 reset commit", {31'd0, commit_req}, 32'd0);
   endtask

   task automatic t_write_basic();
      logic ack;
      int c0 = commit_cnt;
      bus_start();
      write_byte(DEV_W, 1'b0, ack); check("R1 write address ack", {31'd0, ack}, 32'd1);
      write_byte(8'h10, 1'b0, ack); check("R4 pointer byte ack", {31'd0, ack}, 32'd1);
      write_byte(8'hA1, 1'b0, ack); check("R4 data ack", {31'd0, ack}, 32'd1);
      write_byte(8'hA2, 1'b0, ack);
      write_byte(8'hA3, 1'b0, ack);
      bus_stop();
      check("R4 mem[10]", {24'd0, mem[8'h10]}, 32'hA1);
      check("R4 mem[11]", {24'd0, mem[8'h11]}, 32'hA2);
      check("R4 mem[12]", {24'd0, mem[8'h12]}, 32'hA3);
      check("R8 one commit", commit_cnt - c0, 32'd1);
   endtask

   task automatic t_page_wrap();
      logic ack;
      bus_start();
      write_byte(DEV_W, 1'b0, ack);
      write_byte(8'h1E, 1'b0, ack);
      write_byte(8'h11, 1'b0, ack);
      write_byte(8'h22, 1'b0, ack);
      write_byte(8'h33, 1'b0, ack);
      write_byte(8'h44, 1'b0, ack);
      bus_stop();
      check("R5 mem[1E]", {24'd0, mem[8'h1E]}, 32'h11);
      check("R5 mem[1F]", {24'd0, mem[8'h1F]}, 32'h22);
      check("R5 mem[18] after fold", {24'd0, mem[8'h18]}, 32'h33);
      check("R5 mem[19] after fold", {24'd0, mem[8'h19]}, 32'h44);
      check("R5 mem[20] untouched", {24'd0, mem[8'h20]}, {24'd0, 8'h20 ^ 8'h5A});
   endtask

   task automatic t_restart_read();
      logic ack;
      logic [7:0] d;
      bus_start();
      write_byte(DEV_W, 1'b0, ack);
      write_byte(8'h10, 1'b0, ack);
      bus_start();
      write_byte(DEV_R, 1'b0, ack); check("R10 read address ack after restart", {31'd0, ack}, 32'd1);
      read_byte(1'b1, d); check("R6 first read byte", {24'd0, d}, 32'hA1);
      read_byte(1'b1, d); check("R6 second read byte", {24'd0, d}, 32'hA2);
      read_byte(1'b0, d); check("R6 third read byte", {24'd0, d}, 32'hA3);
      read_byte(1'b0, d); check("R7 released after NACK", {24'd0, d}, 32'hFF);
      bus_stop();
   endtask

   task automatic t_read_wrap();
      logic ack;
      logic [7:0] d;
      int c0 = commit_cnt;
      bus_start();
      write_byte(DEV_W, 1'b0, ack);
      write_byte(8'hFE, 1'b0, ack);
      bus_stop();
      check("R8 no commit without data", commit_cnt - c0, 32'd0);
      bus_start();
      write_byte(DEV_R, 1'b0, ack);
      read_byte(1'b1, d); check("R6 read FE", {24'd0, d}, {24'd0, 8'hFE ^ 8'h5A});
      read_byte(1'b1, d); check("R6 read FF", {24'd0, d}, {24'd0, 8'hFF ^ 8'h5A});
      read_byte(1'b0, d); check("R6 read wraps to 00", {24'd0, d}, {24'd0, 8'h00 ^ 8'h5A});
      bus_stop();
   endtask

   task automatic t_mismatch();
      logic ack;
      int w0 = we_cnt;
      int c0 = commit_cnt;
      bus_start();
      write_byte({4'b1010, 3'b100, 1'b0}, 1'b0, ack); check("R2 foreign address nack", {31'd0, ack}, 32'd0);
      write_byte(8'h30, 1'b0, ack); check("R2 no ack while ignoring", {31'd0, ack}, 32'd0);
      write_byte(8'h5C, 1'b0, ack);
      bus_stop();
      check("R2 no write strobe", we_cnt - w0, 32'd0);
      check("R2 no commit", commit_cnt - c0, 32'd0);
   endtask

   task automatic t_busy();
      logic ack;
      busy = 1'b1;
      bus_start();
      write_byte(DEV_W, 1'b0, ack); check("R9 nack while busy", {31'd0, ack}, 32'd0);
      bus_stop();
      busy = 1'b0;
      bus_start();
      write_byte(DEV_W, 1'b0, ack); check("R9 ack once idle", {31'd0, ack}, 32'd1);
      bus_stop();
   endtask

   task automatic t_glitch();
      logic ack;
      bus_start();
      write_byte(DEV_W, 1'b1, ack); check("R11 address ack with glitches", {31'd0, ack}, 32'd1);
      write_byte(8'h40, 1'b1, ack);
      write_byte(8'h96, 1'b1, ack);
      bus_stop();
      check("R11 data intact", {24'd0, mem[8'h40]}, 32'h96);
      check("R11 neighbour untouched", {24'd0, mem[8'h41]}, {24'd0, 8'h41 ^ 8'h5A});
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write_basic();
      t_page_wrap();
      t_restart_read();
      t_read_wrap();
      t_mismatch();
      t_busy();
      t_glitch();
      check("R3 drive steady while SCL high", r3_viol, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule